// File: doc/BRIEF.md
# Phase Detector with Lock Monitor

This block sits between the two frequency dividers of a synthesizer loop and the charge pump. It watches the rising edges of the reference-divider output and the main-divider output on a fast sample clock. It turns the time between those edges into a pump-up or pump-down request. When the reference edge leads, the block asks the pump to source current (up). When the main edge leads, it asks the pump to sink current (down). The request lasts as many sample cycles as the edges are apart. Each comparison ends with both requests held high together for a short fixed window before they clear. This overlap keeps the detector gain linear when the phase error is close to zero.

A 2-bit pump current code travels through a register that only takes a new value while no pulse is running. A lock monitor measures every phase-error pulse in sample cycles and compares it against a threshold. Its flag moves to a new state only after four comparisons in a row point the same way. A software-style enable can turn the monitor off, and the flag then reads high. Dropping the power-on input stops new comparisons from starting, but a pulse that is already running still completes, overlap included.

Top module: `phase_det_lock`

## Requirements
- R1: After reset, `up_o` and `dn_o` are low, `cp_code_o` is 0, and `lock_o` is low while `lock_en_i` is high.
- R2: If the reference input rises d >= 1 sample cycles before the main input, `up_o` is high alone for exactly d cycles, and `dn_o` does not rise before the main edge.
- R3: If the main input rises d >= 1 sample cycles before the reference input, `dn_o` is high alone for exactly d cycles, and `up_o` does not rise before the reference edge.
- R4: If both inputs rise in the same sample cycle, no lone up or down pulse appears; only the overlap window is produced.
- R5: Every comparison ends with `up_o` and `dn_o` both high for exactly OVL_CYC (default 2) cycles. Both then fall in the same cycle.
- R6: While a pulse is waiting for its trailing edge, a second rising edge on the leading input has no effect on the pulse length.
- R7: While `pwr_on_i` is low and the detector is idle, input edges start no pulse. If `pwr_on_i` drops during a pulse, the pulse and its overlap still complete normally.
- R8: `cp_code_o` takes `cp_code_i` only in cycles when the detector is idle. A change made during a pulse appears one cycle after the detector returns to idle.
- R9: A comparison counts as in-lock when its lone up or down time, in sample cycles, is below LOCK_THR (default 4). Simultaneous edges count as an error of 0. A time equal to LOCK_THR counts as out-of-lock.
- R10: The monitor flag changes only after AGREE_N (default 4) consecutive comparisons all disagree with its current value. Any agreeing comparison restarts that count.
- R11: While `lock_en_i` is low, `lock_o` is high and the internal flag is held out-of-lock with its count cleared. After the monitor is enabled again, it starts out-of-lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on_i | input | 1 | Combined power-on; low stops new comparisons |
| lock_en_i | input | 1 | Lock monitor enable |
| ref_div_i | input | 1 | Reference divider output |
| main_div_i | input | 1 | Main divider output |
| cp_code_i | input | CODE_W | Requested pump current code |
| up_o | output | 1 | Pump source request |
| dn_o | output | 1 | Pump sink request |
| cp_code_o | output | CODE_W | Registered pump current code |
| lock_o | output | 1 | Lock flag, high when locked or monitor off |

## Verification
Several properties are checked on every cycle. A lone up or down request can only end by entering the overlap. The overlap lasts at least two cycles and ends with both requests falling together. The current code stays still while a request is active. Power-down keeps an idle detector silent. The lock flag forces high when disabled, and it only changes on the cycle a comparison lands. The exact pulse lengths for each edge order, the threshold boundary, the four-in-a-row hysteresis, the late arrival of a code change and the completion of a pulse through power-down can only be shown by the bench scenarios, which compare against a reference model of the requirements.

// File: rtl/pdl_pkg.sv
package pdl_pkg;
  typedef enum logic [1:0] {
    PD_IDLE = 2'd0,
    PD_UP   = 2'd1,
    PD_DN   = 2'd2,
    PD_OVL  = 2'd3
  } pd_state_e;
endpackage

// File: rtl/pdl_edge.sv
module pdl_edge #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= sig_i[i];
    end
    assign rise_o[i] = sig_i[i] & ~prev_q[i];
  end
endmodule

// File: rtl/pdl_detector.sv
module pdl_detector
  import pdl_pkg::*;
#(
  parameter int unsigned OVL_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_on_i,
  input  logic ref_rise_i,
  input  logic main_rise_i,
  output logic up_o,
  output logic dn_o,
  output logic idle_o,
  output logic busy_o,
  output logic cmp_o
);
  localparam int unsigned OC_W = (OVL_CYC > 1) ? $clog2(OVL_CYC) : 1;
  localparam logic [OC_W-1:0] OC_LAST = OC_W'(OVL_CYC - 1);

  pd_state_e       state_q, state_d;
  logic [OC_W-1:0] ovl_q, ovl_d;

  // Next-state: R2 R3 R4 R6 R7
  always_comb begin
    state_d = state_q;
    ovl_d   = '0;
    unique case (state_q)
      PD_IDLE: begin
        if (pwr_on_i) begin
          if (ref_rise_i && main_rise_i) state_d = PD_OVL;
          else if (ref_rise_i)           state_d = PD_UP;
          else if (main_rise_i)          state_d = PD_DN;
        end
      end
      PD_UP:   if (main_rise_i) state_d = PD_OVL;
      PD_DN:   if (ref_rise_i)  state_d = PD_OVL;
      PD_OVL: begin
        if (ovl_q == OC_LAST) state_d = PD_IDLE;
        else                  ovl_d   = ovl_q + 1'b1;
      end
      default: state_d = PD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PD_IDLE;
      ovl_q   <= '0;
    end else begin
      state_q <= state_d;
      ovl_q   <= ovl_d;
    end
  end

  // R5: overlap state drives both requests
  assign up_o   = (state_q == PD_UP) || (state_q == PD_OVL);
  assign dn_o   = (state_q == PD_DN) || (state_q == PD_OVL);
  assign idle_o = (state_q == PD_IDLE);
  assign busy_o = (state_q == PD_UP) || (state_q == PD_DN);
  assign cmp_o  = (state_q != PD_OVL) && (state_d == PD_OVL);
endmodule

// File: rtl/pdl_lock_mon.sv
module pdl_lock_mon #(
  parameter int unsigned LOCK_THR = 4,
  parameter int unsigned AGREE_N  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic busy_i,
  input  logic cmp_i,
  output logic lock_o
);
  localparam int unsigned ERR_W = $clog2(LOCK_THR + 1);
  localparam int unsigned STK_W = (AGREE_N > 1) ? $clog2(AGREE_N) : 1;
  localparam logic [ERR_W-1:0] ERR_SAT = ERR_W'(LOCK_THR);
  localparam logic [ERR_W:0]   THR_EXT = (ERR_W+1)'(LOCK_THR);
  localparam logic [STK_W-1:0] STK_LAST = STK_W'(AGREE_N - 1);

  logic [ERR_W-1:0] err_q, err_d;
  logic [STK_W-1:0] stk_q, stk_d;
  logic             flag_q, flag_d;
  logic [ERR_W:0]   meas;
  logic             good;

  // Saturating error-time counter
  always_comb begin
    if (!busy_i)               err_d = '0;
    else if (err_q == ERR_SAT) err_d = err_q;
    else                       err_d = err_q + 1'b1;
  end

  // R9: compare lone-pulse time with threshold
  assign meas = {1'b0, err_q} + {{ERR_W{1'b0}}, 1'b1};
  assign good = !busy_i || (meas < THR_EXT);

  // R10 R11: hysteresis on consecutive disagreements
  always_comb begin
    flag_d = flag_q;
    stk_d  = stk_q;
    if (!en_i) begin
      flag_d = 1'b0;
      stk_d  = '0;
    end else if (cmp_i) begin
      if (good != flag_q) begin
        if (stk_q == STK_LAST) begin
          flag_d = good;
          stk_d  = '0;
        end else begin
          stk_d  = stk_q + 1'b1;
        end
      end else begin
        stk_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= '0;
      stk_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      err_q  <= err_d;
      stk_q  <= stk_d;
      flag_q <= flag_d;
    end
  end

  assign lock_o = !en_i || flag_q;
endmodule

// File: rtl/phase_det_lock.sv
module phase_det_lock #(
  parameter int unsigned CODE_W   = 2,
  parameter int unsigned OVL_CYC  = 2,
  parameter int unsigned LOCK_THR = 4,
  parameter int unsigned AGREE_N  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on_i,
  input  logic              lock_en_i,
  input  logic              ref_div_i,
  input  logic              main_div_i,
  input  logic [CODE_W-1:0] cp_code_i,
  output logic              up_o,
  output logic              dn_o,
  output logic [CODE_W-1:0] cp_code_o,
  output logic              lock_o
);
  localparam int unsigned N_IN = 2;

  logic [1:0]        rs_q;
  logic              rst_int_n;
  logic [N_IN-1:0]   rise;
  logic              idle, busy, cmp;
  logic [CODE_W-1:0] code_q, code_d;

  // Reset asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  pdl_edge #(.W(N_IN)) u_edge (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .sig_i  ({main_div_i, ref_div_i}),
    .rise_o (rise)
  );

  pdl_detector #(.OVL_CYC(OVL_CYC)) u_det (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .pwr_on_i    (pwr_on_i),
    .ref_rise_i  (rise[0]),
    .main_rise_i (rise[1]),
    .up_o        (up_o),
    .dn_o        (dn_o),
    .idle_o      (idle),
    .busy_o      (busy),
    .cmp_o       (cmp)
  );

  pdl_lock_mon #(.LOCK_THR(LOCK_THR), .AGREE_N(AGREE_N)) u_mon (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .en_i   (lock_en_i),
    .busy_i (busy),
    .cmp_i  (cmp),
    .lock_o (lock_o)
  );

  // R8: code register loads only while idle
  always_comb code_d = idle ? cp_code_i : code_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) code_q <= '0;
    else            code_q <= code_d;
  end
  assign cp_code_o = code_q;
endmodule

// File: rtl/phase_det_lock_chk.sv
module phase_det_lock_chk #(
  parameter int unsigned CODE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_on_i,
  input logic              lock_en_i,
  input logic              up_o,
  input logic              dn_o,
  input logic [CODE_W-1:0] cp_code_o,
  input logic              lock_o
);
  // R2
  up_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_o && !dn_o) |=> up_o);

  // R3
  dn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_o && !up_o) |=> dn_o);

  // R5
  ovl_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_o && dn_o) |=> (up_o && dn_o));

  // R5
  ovl_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(up_o && dn_o) |-> (!up_o && !dn_o));

  // R7
  pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_on_i && !up_o && !dn_o) |=> (!up_o && !dn_o));

  // R8
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_o || dn_o) |=> $stable(cp_code_o));

  // R11
  lock_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_en_i |-> lock_o);

  // R10
  lock_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_en_i && $past(lock_en_i) && (lock_o != $past(lock_o)))
      |-> (up_o && dn_o && !$past(up_o && dn_o)));
endmodule

bind phase_det_lock phase_det_lock_chk #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_on_i  (pwr_on_i),
  .lock_en_i (lock_en_i),
  .up_o      (up_o),
  .dn_o      (dn_o),
  .cp_code_o (cp_code_o),
  .lock_o    (lock_o)
);

// File: tb/phase_det_lock_tb.sv
module phase_det_lock_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int THR = 4;
  localparam int AGR = 4;

  logic       clk = 1'b0;
  logic       rst_n, pwr_on, lock_en, ref_div, main_div;
  logic [1:0] code_in, code_out;
  logic       up, dn, lock;

  int n_chk = 0;
  int n_fail = 0;
  bit m_flag = 1'b0;
  int m_stk = 0;
  logic [1:0] m_code = 2'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_det_lock u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_on_i(pwr_on), .lock_en_i(lock_en),
    .ref_div_i(ref_div), .main_div_i(main_div), .cp_code_i(code_in),
    .up_o(up), .dn_o(dn), .cp_code_o(code_out), .lock_o(lock)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model of the monitor (R9 R10 R11)
  function automatic void model_cmp(input bit good);
    if (!lock_en) begin m_flag = 1'b0; m_stk = 0; end
    else if (good != m_flag) begin
      m_stk++;
      if (m_stk == AGR) begin m_flag = good; m_stk = 0; end
    end else m_stk = 0;
  endfunction

  function automatic bit exp_lock();
    return !lock_en || m_flag;
  endfunction

  // lead: 0 reference first, 1 main first, 2 same cycle
  task automatic run_cmp(input int lead, input int d, input bit pd_mid,
                         input bit extra, input bit chg, input logic [1:0] nc);
    int n_up = 0, n_dn = 0, n_both = 0;
    string rq;
    rq = (lead == 0) ? "R2" : (lead == 1) ? "R3" : "R4";
    if (lead == 2) d = 0;
    if (lead != 1) ref_div = 1'b1;
    if (lead != 0) main_div = 1'b1;
    for (int i = 0; i < d; i++) begin
      @(negedge clk);
      if (up && !dn) n_up++;
      if (dn && !up) n_dn++;
      if (up && dn) n_both++;
      if (i == 0 && chg) code_in = nc;
      if (i == 1 && pd_mid) pwr_on = 1'b0;
      if (extra && i == 1) begin if (lead == 0) ref_div = 1'b0; else main_div = 1'b0; end
      if (extra && i == 2) begin if (lead == 0) ref_div = 1'b1; else main_div = 1'b1; end
    end
    ref_div = 1'b1;
    main_div = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(up && dn, "R5 overlap", {up, dn}, 3);
    end
    @(negedge clk);
    chk(!up && !dn, "R5 end", {up, dn}, 0);
    chk(n_up == ((lead == 0) ? d : 0), {rq, " up cycles"}, n_up, (lead == 0) ? d : 0);
    chk(n_dn == ((lead == 1) ? d : 0), {rq, " dn cycles"}, n_dn, (lead == 1) ? d : 0);
    chk(n_both == 0, {rq, " early overlap"}, n_both, 0);
    if (extra) chk(n_up + n_dn == d, "R6 extra lead edge", n_up + n_dn, d);
    if (pd_mid) chk(n_up + n_dn == d, "R7 pulse completes", n_up + n_dn, d);
    chk(code_out == m_code, "R8 code held", code_out, m_code);
    ref_div = 1'b0;
    main_div = 1'b0;
    pwr_on = 1'b1;
    @(negedge clk);
    if (chg) m_code = nc;
    chk(code_out == m_code, "R8 code updated", code_out, m_code);
    model_cmp((lead == 2) || (d < THR));
    chk(lock == exp_lock(), "R9 R10 lock flag", lock, exp_lock());
    @(negedge clk);
  endtask

  task automatic pd_idle();
    pwr_on = 1'b0;
    ref_div = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(!up && !dn, "R7 idle power-down", {up, dn}, 0);
    end
    main_div = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(!up && !dn, "R7 idle power-down", {up, dn}, 0);
    end
    ref_div = 1'b0; main_div = 1'b0;
    @(negedge clk);
    pwr_on = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!up && !dn, "R7 no late pulse", {up, dn}, 0);
  endtask

  task automatic set_en(input bit e);
    lock_en = e;
    if (!e) begin m_flag = 1'b0; m_stk = 0; end
    @(negedge clk);
    @(negedge clk);
    chk(lock == exp_lock(), "R11 enable change", lock, exp_lock());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c_77a5));
    rst_n = 1'b0; pwr_on = 1'b1; lock_en = 1'b1;
    ref_div = 1'b0; main_div = 1'b0; code_in = 2'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!up && !dn, "R1 reset requests", {up, dn}, 0);
    chk(code_out == 2'd0, "R1 reset code", code_out, 0);
    chk(lock == 1'b0, "R1 reset lock", lock, 0);

    // R9: four good comparisons reach lock
    for (int i = 0; i < 4; i++) run_cmp(0, 1, 0, 0, 0, 2'd0);
    chk(lock == 1'b1, "R9 locked after four", lock, 1);
    // R10: three bad, one good, three bad keep lock
    for (int i = 0; i < 3; i++) run_cmp(1, 6, 0, 0, 0, 2'd0);
    run_cmp(2, 0, 0, 0, 0, 2'd0);
    for (int i = 0; i < 3; i++) run_cmp(1, THR, 0, 0, 0, 2'd0);
    chk(lock == 1'b1, "R10 restart count", lock, 1);
    run_cmp(0, THR, 0, 0, 0, 2'd0);
    chk(lock == 1'b0, "R10 drops on fourth", lock, 0);
    // R9 boundary THR-1 good
    for (int i = 0; i < 4; i++) run_cmp(i % 2, THR - 1, 0, 0, 0, 2'd0);
    chk(lock == 1'b1, "R9 boundary below threshold", lock, 1);
    // R6 R7 R8 directed
    run_cmp(0, 6, 0, 1, 0, 2'd0);
    run_cmp(1, 5, 0, 1, 0, 2'd0);
    run_cmp(0, 4, 1, 0, 1, 2'd3);
    run_cmp(1, 3, 1, 0, 1, 2'd1);
    pd_idle();
    // R11
    set_en(1'b0);
    for (int i = 0; i < 5; i++) run_cmp(1, 7, 0, 0, 0, 2'd0);
    chk(lock == 1'b1, "R11 disabled high", lock, 1);
    set_en(1'b1);
    chk(lock == 1'b0, "R11 re-enable out-of-lock", lock, 0);

    for (int k = 0; k < 60; k++) begin
      int ld, dd;
      bit pm, ex, cg;
      ld = $urandom_range(0, 2);
      dd = (ld == 2) ? 0 : $urandom_range(1, 9);
      pm = (dd >= 3) && ($urandom_range(0, 3) == 0);
      ex = (dd >= 4) && ($urandom_range(0, 3) == 0);
      cg = (dd >= 1) && ($urandom_range(0, 1) == 1);
      if ($urandom_range(0, 19) == 0) set_en(!lock_en);
      run_cmp(ld, dd, pm, ex, cg, 2'($urandom_range(0, 3)));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule